// File: doc/BRIEF.md
# Unsigned 128-by-64 Divide-Modulo Unit

This unit takes a 128-bit unsigned dividend, supplied as an upper and a lower 64-bit word, and a 64-bit unsigned divisor. It returns a 64-bit quotient and a 64-bit remainder from one operation. A start strobe launches the operation, and a one-cycle done strobe marks the cycle in which both results become valid. The results then hold until the next accepted start.

Before iterating, the unit screens the operands. A quotient fits in 64 bits only when the upper dividend word is below the divisor, and that test also catches a zero divisor. If the screen fails, the unit skips iteration and returns saturated values: a quotient of all ones and a remainder of zero. Otherwise a restoring divider produces one quotient bit per clock. The upper dividend word seeds the partial remainder, so exactly 64 steps are needed. The unit raises no status or flag signals; software detects the overflow case from the saturated quotient.

Top module: `divmod_unit`

## Requirements
- R1: When dvd_hi < divisor (unsigned) and the divisor is nonzero, quo equals floor({dvd_hi,dvd_lo} / divisor) and rem equals {dvd_hi,dvd_lo} mod divisor. The dividend is dvd_hi in bits 127:64 over dvd_lo in bits 63:0, and the divisor is zero-extended.
- R2: When dvd_hi >= divisor with a nonzero divisor, quo is all ones and rem is zero.
- R3: When the divisor is zero, quo is all ones and rem is zero, whatever the dividend words hold.
- R4: A start that fails the screen raises done immediately after the clock edge that samples start.
- R5: A start that passes the screen raises done after the 64th clock edge following the edge that samples start.
- R6: done is high for one cycle per accepted start. quo and rem change only at the edge that raises done and otherwise hold their values.
- R7: A start asserted while an operation is iterating is ignored. The running operation finishes with its own operands and timing.
- R8: During and after synchronous reset, done is low and quo and rem read zero.
- R9: The largest valid upper word (dvd_hi = divisor - 1) gives exact results, including an all-ones quotient that is not an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch an operation with the present operands |
| dvd_hi | input | 64 | Upper word of the dividend |
| dvd_lo | input | 64 | Lower word of the dividend |
| divisor | input | 64 | Divisor |
| quo | output | 64 | Quotient, valid from done |
| rem | output | 64 | Remainder, valid from done |
| done | output | 1 | One-cycle strobe: results are valid |

## Verification
A partial remainder that ever reaches or passes the divisor is corrupted internally, yet nothing shows at the ports until done. At done it appears as a wrong quotient bit pattern and a wrong remainder, which is why every result is compared against an exact 128-bit division. A step counter that is off by one moves done by one edge and also shifts the quotient by one position, so the latency check and the value check each expose it at the first valid operation. A bad screen decision shows within a single cycle, either as a missing early done or as saturated values that should not appear.

// File: rtl/divmod_pkg.sv
package divmod_pkg;
    localparam int DEF_W = 64;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic accept;
        logic running;
        logic final_step;
        logic idle;
    } ctrl_t;
endpackage

// File: rtl/divmod_screen.sv
module divmod_screen #(
    parameter int W = divmod_pkg::DEF_W
) (
    input  logic [W-1:0] upper,
    input  logic [W-1:0] dv,
    output logic         fits
);
    // quotient fits in W bits only when upper word < divisor; also rejects dv == 0
    always_comb fits = (dv != '0) && (upper < dv);
endmodule

// File: rtl/divmod_step.sv
module divmod_step #(
    parameter int W = divmod_pkg::DEF_W
) (
    input  logic [W-1:0] part_in,
    input  logic         next_bit,
    input  logic [W-1:0] dv,
    output logic [W-1:0] part_out,
    output logic         q_bit
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        shifted  = {part_in, next_bit};
        trial    = shifted - {1'b0, dv};
        q_bit    = (shifted >= {1'b0, dv});
        part_out = q_bit ? trial[W-1:0] : shifted[W-1:0];
    end
endmodule

// File: rtl/divmod_ctrl.sv
module divmod_ctrl #(
    parameter int W = divmod_pkg::DEF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                fits,
    output divmod_pkg::ctrl_t   ctl
);
    import divmod_pkg::*;

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    phase_e        phase_r;
    logic [CW-1:0] cnt_r;

    always_comb begin
        ctl.idle       = (phase_r == PH_IDLE);
        ctl.accept     = start && ctl.idle;
        ctl.running    = (phase_r == PH_RUN);
        ctl.final_step = ctl.running && (cnt_r == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_r <= PH_IDLE;
            cnt_r   <= '0;
        end else if (ctl.accept && fits) begin
            phase_r <= PH_RUN;
            cnt_r   <= '0;
        end else if (ctl.running) begin
            cnt_r <= cnt_r + 1'b1;
            if (cnt_r == LAST) phase_r <= PH_IDLE;
        end
    end

    AST_COUNT_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.running) |-> (cnt_r == '0)) else $error("count not cleared"); // R5
    AST_IGNORE_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (ctl.running && !ctl.final_step) |=> ctl.running) else $error("run cut short"); // R7
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit #(
    parameter int W = divmod_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         done
);
    import divmod_pkg::*;

    ctrl_t        ctl;
    logic         fits;
    logic [W:0]   part_r;   // one spare bit above the divisor width
    logic [W-1:0] shf_r;    // low dividend bits out the top, quotient bits in the bottom
    logic [W-1:0] dv_r;
    logic [W-1:0] quo_r;
    logic [W-1:0] rem_r;
    logic         done_r;
    logic [W-1:0] part_nx;
    logic         qb;

    divmod_screen #(.W(W)) u_screen (
        .upper (dvd_hi),
        .dv    (divisor),
        .fits  (fits)
    );

    divmod_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .fits  (fits),
        .ctl   (ctl)
    );

    divmod_step #(.W(W)) u_step (
        .part_in  (part_r[W-1:0]),
        .next_bit (shf_r[W-1]),
        .dv       (dv_r),
        .part_out (part_nx),
        .q_bit    (qb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            part_r <= '0;
            shf_r  <= '0;
            dv_r   <= '0;
            quo_r  <= '0;
            rem_r  <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (ctl.accept && fits) begin
                part_r <= {1'b0, dvd_hi};
                shf_r  <= dvd_lo;
                dv_r   <= divisor;
            end else if (ctl.accept) begin
                quo_r  <= '1;
                rem_r  <= '0;
                done_r <= 1'b1;
            end else if (ctl.running) begin
                part_r <= {1'b0, part_nx};
                shf_r  <= {shf_r[W-2:0], qb};
                if (ctl.final_step) begin
                    quo_r  <= {shf_r[W-2:0], qb};
                    rem_r  <= part_nx;
                    done_r <= 1'b1;
                end
            end
        end
    end

    assign quo  = quo_r;
    assign rem  = rem_r;
    assign done = done_r;

    AST_PART_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        ctl.running |-> (part_r < {1'b0, dv_r})) else $error("partial remainder too large"); // R1
    AST_SPARE_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ctl.running |-> !part_r[W]) else $error("spare bit set"); // R9
    AST_ERR_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
        (ctl.accept && !fits) |=> (done && quo == '1 && rem == '0)) else $error("bad error result"); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !done) else $error("done held"); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quo) && $stable(rem))) else $error("result moved"); // R6
    AST_DONE_NOT_RUNNING: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, ctl.running})) else $error("done while running"); // R5
endmodule

// File: tb/divmod_unit_tb.sv
module divmod_unit_tb;
    localparam int W = 64;
    localparam int NV = 10;

    // each entry: {dvd_hi, dvd_lo, divisor}
    localparam logic [3*W-1:0] VEC [NV] = '{
        {64'd0,                  64'd100,                 64'd7},
        {64'd1,                  64'd0,                   64'd2},
        {64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {64'd0,                  64'hDEAD_BEEF_0123_4567, 64'd1},
        {64'd5,                  64'h0F0F_1234_ABCD_9876, 64'h8000_0000_0000_0001},
        {64'h0000_1234_5678_9ABB, 64'h5555_AAAA_3333_CCCC, 64'h0000_1234_5678_9ABC},
        {64'd7,                  64'd99,                  64'd7},
        {64'hFFFF_0000_0000_0000, 64'd1,                  64'd3},
        {64'd0,                  64'd55,                  64'd0},
        {64'd2,                  64'h0123_4567_89AB_CDEF, 64'd3}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dvd_hi = '0;
    logic [W-1:0] dvd_lo = '0;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] quo;
    logic [W-1:0] rem;
    logic         done;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    divmod_unit #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .quo(quo), .rem(rem), .done(done)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_result(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                 input logic [W-1:0] d,
                                 output logic [W-1:0] eq, output logic [W-1:0] er,
                                 output bit ok);
        logic [127:0] n;
        logic [127:0] dd;
        logic [127:0] qq;
        logic [127:0] rr;
        n  = {hi, lo};
        dd = {64'd0, d};
        ok = (d != 0) && (hi < d);
        if (ok) begin
            qq = n / dd;
            rr = n % dd;
            eq = qq[W-1:0];
            er = rr[W-1:0];
        end else begin
            eq = '1;
            er = '0;
        end
    endtask

    // pulse start at a negedge; returns edges after the sampling edge until done seen
    task automatic launch_and_wait(input logic [W-1:0] hi, input logic [W-1:0] lo,
                                   input logic [W-1:0] d, output int lat);
        @(negedge clk);
        dvd_hi = hi; dvd_lo = lo; divisor = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] eq, er;
        logic [W-1:0] sq, sr;
        bit ok;
        int lat;
        string tag;

        repeat (3) @(negedge clk);
        check("R8 reset done", {127'd0, done}, 128'd0);
        check("R8 reset quo/rem", {quo, rem}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after reset", {quo, rem, 63'd0, done}, 128'd0);

        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] hi, lo, d;
            {hi, lo, d} = VEC[i];
            expect_result(hi, lo, d, eq, er, ok);
            if (d == 0) tag = "R3";
            else if (hi >= d) tag = "R2";
            else if (hi == d - 1) tag = "R9";
            else tag = "R1";
            launch_and_wait(hi, lo, d, lat);
            check({tag, " quotient"}, {64'd0, quo}, {64'd0, eq});
            check({tag, " remainder"}, {64'd0, rem}, {64'd0, er});
            check(ok ? "R5 latency" : "R4 latency", 128'(lat), ok ? 128'd64 : 128'd0);
            @(negedge clk);
            check("R6 done pulse", {127'd0, done}, 128'd0);
        end

        // R6: results hold while inputs change without start
        sq = quo; sr = rem;
        dvd_hi = 64'd9; dvd_lo = 64'd1; divisor = 64'd0;
        repeat (6) @(negedge clk);
        check("R6 hold", {quo, rem}, {sq, sr});

        // R7: a second start during iteration is ignored
        expect_result(64'd3, 64'hAAAA_0000_1111_2222, 64'd11, eq, er, ok);
        @(negedge clk);
        dvd_hi = 64'd3; dvd_lo = 64'hAAAA_0000_1111_2222; divisor = 64'd11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (10) begin @(negedge clk); lat++; end
        dvd_hi = 64'd0; dvd_lo = 64'd1000; divisor = 64'd0; start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        check("R7 no early done", {127'd0, done}, 128'd0);
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check("R7 latency", 128'(lat), 128'd64);
        check("R7 result", {quo, rem}, {eq, er});

        // R9: boundary with the all-ones quotient from a small divisor
        expect_result(64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, eq, er, ok);
        launch_and_wait(64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, lat);
        check("R9 boundary", {quo, rem}, {eq, er});
        check("R9 latency", 128'(lat), 128'd64);

        // R3: zero divisor right after a valid result, back to back
        launch_and_wait(64'hFFFF, 64'd5, 64'd0, lat);
        check("R3 zero divisor", {quo, rem}, {64'hFFFF_FFFF_FFFF_FFFF, 64'd0});
        check("R4 zero divisor latency", 128'(lat), 128'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule